// File: doc/BRIEF.md
# Dual-Port Burst-of-Two Static Memory Engine

This block models a static memory with a separate read port and write port, each opened by its own active-low select. It runs on one internal clock at twice the K rate. An input phase flag tells the block, on every edge, whether that edge stands for a K rising edge or a K# rising edge. Every transaction moves a fixed pair of 18-bit words, low word first. Both halves of the pair belong to one 36-bit double word at the given address. A new read and a new write may each start on every K edge.

Writes pass through a staging register before they reach the array. The staged double word goes into the array when the next write completes. Until then, any read of that address takes the staged bytes, so a read always sees the newest data, even one half-cycle after the write ends. Read data comes out through output registers. An output-enable flag falls by itself whenever no read word is on the bus.

Top module: `qdr_burst_sram`

## Requirements
- R1: A read is accepted only when `rd_n` is low on an edge where `k_edge` is 1. The read address is sampled on that same edge. `rd_n` low on a K# edge (`k_edge` 0) starts nothing.
- R2: For a read accepted on K edge t (counted in internal clock edges), the first word is on `rdata` after edge t+2 and the second word is there after edge t+3.
- R3: Out of reset, `rdata_oe` and `rdata` are 0. On a K edge with no read word to drive, `rdata_oe` falls to 0 and `rdata` to 0, and both stay there until a read word is due.
- R4: A write is accepted when `wr_n` is low on a K edge. The low word and `be_n` are taken on that edge. The address, the high word and its `be_n` are taken on the K# edge that follows.
- R5: `be_n` is active low. `be_n[0]` covers word bits 8:0 and `be_n[1]` covers bits 17:9. A byte whose enable is high keeps its old contents.
- R6: The word written or read first is bits 17:0 of the double word at the address. The word second is bits 35:18.
- R7: A read accepted on the same K edge as a write to the same address, or on any later K edge, returns the written data, including while it is still staged.
- R8: A read of a partly written staged double word returns the enabled bytes from the staging register and the other bytes from the array.
- R9: Reads on consecutive K edges produce an unbroken stream of words with `rdata_oe` held at 1. Writes on consecutive K edges are all stored.
- R10: `wr_n` low on a K# edge with no write accepted on the preceding K edge stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the K rate |
| rst_n | input | 1 | Active-low synchronous reset |
| k_edge | input | 1 | 1 on edges that stand for K, 0 on edges that stand for K# |
| rd_n | input | 1 | Read select, active low, sampled on K edges |
| rd_addr | input | ADDR_W | Double-word read address |
| wr_n | input | 1 | Write select, active low, sampled on K edges |
| wr_addr | input | ADDR_W | Double-word write address, sampled on the K# edge of a write |
| wdata | input | WORD_W | Write word, low half on K and high half on K# |
| be_n | input | WORD_W/LANE_W | Active-low byte enables for the current write word |
| rdata | output | WORD_W | Read word |
| rdata_oe | output | 1 | High while a read word is driven on `rdata` |

## Verification
The two functions that can fall in one cycle are a read lookup and a staged write that has not yet reached the array. When a read and a write name the same address on the same K edge, the read's lookup two edges later finds the new data only in staging. The bench provokes this on every address, and again with all sixteen byte-enable patterns on each address, so that forwarded and array bytes mix within one double word. Each returned word is compared against a reference memory that the bench updates in request order, and the contents are read back after the commits.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int DEF_ADDR_W = 4;
  localparam int DEF_WORD_W = 18;
  localparam int DEF_LANE_W = 9;

  // number of byte lanes in a field of the given width
  function automatic int lanes(input int width, input int lane_w);
    return width / lane_w;
  endfunction
endpackage

// File: rtl/qdr_lane_merge.sv
module qdr_lane_merge #(
  parameter int DW     = 36,
  parameter int LANE_W = 9
) (
  input  logic [DW-1:0]        old_d,
  input  logic [DW-1:0]        new_d,
  input  logic [DW/LANE_W-1:0] mask,
  output logic [DW-1:0]        merged
);
  localparam int NL = qdr_pkg::lanes(DW, LANE_W);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign merged[i*LANE_W +: LANE_W] = mask[i] ? new_d[i*LANE_W +: LANE_W]
                                                : old_d[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/qdr_mem_array.sv
module qdr_mem_array #(
  parameter int ADDR_W = 4,
  parameter int DW     = 36,
  parameter int LANE_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [DW-1:0]        wdata,
  input  logic [DW/LANE_W-1:0] wmask,
  input  logic [ADDR_W-1:0]    raddr,
  output logic [DW-1:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] old_word;
  logic [DW-1:0] new_word;

  assign old_word = cells[waddr];
  assign rdata    = cells[raddr];

  qdr_lane_merge #(.DW(DW), .LANE_W(LANE_W)) u_commit_merge (
    .old_d (old_word),
    .new_d (wdata),
    .mask  (wmask),
    .merged(new_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= new_word;
    end
  end
endmodule

// File: rtl/qdr_write_stage.sv
module qdr_write_stage #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18,
  parameter int LANE_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        k_edge,
  input  logic                        wr_n,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [WORD_W/LANE_W-1:0]    be_n,
  output logic                        write_done,
  output logic                        commit_en,
  output logic                        stg_v,
  output logic [ADDR_W-1:0]           stg_addr,
  output logic [2*WORD_W-1:0]         stg_data,
  output logic [2*WORD_W/LANE_W-1:0]  stg_mask
);
  localparam int HL = qdr_pkg::lanes(WORD_W, LANE_W);

  logic              wact;
  logic [WORD_W-1:0] wlo;
  logic [HL-1:0]     wmask_lo;

  // second half of a write lands on this K# edge; the previous staged
  // double word is pushed into the array on the same edge
  assign write_done = !k_edge && wact;
  assign commit_en  = write_done && stg_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wact     <= 1'b0;
      wlo      <= '0;
      wmask_lo <= '0;
      stg_v    <= 1'b0;
      stg_addr <= '0;
      stg_data <= '0;
      stg_mask <= '0;
    end else if (k_edge) begin
      wact <= !wr_n;
      if (!wr_n) begin
        wlo      <= wdata;
        wmask_lo <= ~be_n;
      end
    end else if (wact) begin
      wact     <= 1'b0;
      stg_v    <= 1'b1;
      stg_addr <= wr_addr;
      stg_data <= {wdata, wlo};
      stg_mask <= {~be_n, wmask_lo};
    end
  end
endmodule

// File: rtl/qdr_read_pipe.sv
module qdr_read_pipe #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18,
  parameter int LANE_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        k_edge,
  input  logic                        rd_n,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [2*WORD_W-1:0]         arr_q,
  input  logic                        stg_v,
  input  logic [ADDR_W-1:0]           stg_addr,
  input  logic [2*WORD_W-1:0]         stg_data,
  input  logic [2*WORD_W/LANE_W-1:0]  stg_mask,
  output logic [ADDR_W-1:0]           pend_addr,
  output logic                        fwd_hit,
  output logic [WORD_W-1:0]           rdata,
  output logic                        rdata_oe
);
  localparam int DW = 2 * WORD_W;
  localparam int NL = qdr_pkg::lanes(DW, LANE_W);

  logic              pend_v;
  logic              hi_v;
  logic [WORD_W-1:0] hi_hold;
  logic [DW-1:0]     coherent;
  logic [NL-1:0]     fwd_mask;

  assign fwd_hit  = pend_v && stg_v && (stg_addr == pend_addr);
  assign fwd_mask = fwd_hit ? stg_mask : '0;

  qdr_lane_merge #(.DW(DW), .LANE_W(LANE_W)) u_fwd_merge (
    .old_d (arr_q),
    .new_d (stg_data),
    .mask  (fwd_mask),
    .merged(coherent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      hi_v      <= 1'b0;
      hi_hold   <= '0;
      rdata     <= '0;
      rdata_oe  <= 1'b0;
    end else if (k_edge) begin
      pend_v    <= !rd_n;
      pend_addr <= rd_addr;
      if (pend_v) begin
        rdata    <= coherent[WORD_W-1:0];
        hi_hold  <= coherent[DW-1:WORD_W];
        hi_v     <= 1'b1;
        rdata_oe <= 1'b1;
      end else begin
        rdata    <= '0;
        hi_v     <= 1'b0;
        rdata_oe <= 1'b0;
      end
    end else if (hi_v) begin
      rdata <= hi_hold;
      hi_v  <= 1'b0;
    end
  end
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int ADDR_W = qdr_pkg::DEF_ADDR_W,
  parameter int WORD_W = qdr_pkg::DEF_WORD_W,
  parameter int LANE_W = qdr_pkg::DEF_LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     k_edge,
  input  logic                     rd_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     wr_n,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [WORD_W/LANE_W-1:0] be_n,
  output logic [WORD_W-1:0]        rdata,
  output logic                     rdata_oe
);
  localparam int DW = 2 * WORD_W;
  localparam int NL = qdr_pkg::lanes(DW, LANE_W);

  logic              write_done;
  logic              commit_en;
  logic              stg_v;
  logic [ADDR_W-1:0] stg_addr;
  logic [DW-1:0]     stg_data;
  logic [NL-1:0]     stg_mask;
  logic [ADDR_W-1:0] pend_addr;
  logic              fwd_hit;
  logic [DW-1:0]     arr_q;

  qdr_write_stage #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_wstage (
    .clk       (clk),
    .rst_n     (rst_n),
    .k_edge    (k_edge),
    .wr_n      (wr_n),
    .wr_addr   (wr_addr),
    .wdata     (wdata),
    .be_n      (be_n),
    .write_done(write_done),
    .commit_en (commit_en),
    .stg_v     (stg_v),
    .stg_addr  (stg_addr),
    .stg_data  (stg_data),
    .stg_mask  (stg_mask)
  );

  qdr_mem_array #(.ADDR_W(ADDR_W), .DW(DW), .LANE_W(LANE_W)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (commit_en),
    .waddr(stg_addr),
    .wdata(stg_data),
    .wmask(stg_mask),
    .raddr(pend_addr),
    .rdata(arr_q)
  );

  qdr_read_pipe #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_rpipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .k_edge   (k_edge),
    .rd_n     (rd_n),
    .rd_addr  (rd_addr),
    .arr_q    (arr_q),
    .stg_v    (stg_v),
    .stg_addr (stg_addr),
    .stg_data (stg_data),
    .stg_mask (stg_mask),
    .pend_addr(pend_addr),
    .fwd_hit  (fwd_hit),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic k_edge,
  input logic rd_n,
  input logic wr_n,
  input logic rdata_oe,
  input logic stg_v,
  input logic write_done
);
  // R1, R2: a read accepted on a K edge drives two words from edge t+2
  a_r2_read_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (k_edge && !rd_n) |=> ##2 rdata_oe ##1 rdata_oe);

  // R3: no read accepted means the bus is released two edges later
  a_r3_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (k_edge && rd_n) |=> ##2 !rdata_oe);

  // R3: the bus is only released by a K edge
  a_r3_fall_on_k: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata_oe) |-> $past(k_edge));

  // R4: a write accepted on K completes on the following K# edge
  a_r4_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (k_edge && !wr_n) |=> write_done ##1 stg_v);

  // R4: staging is first loaded only by a K# edge
  a_r4_stage_on_kbar: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stg_v) |-> $past(!k_edge));
endmodule

bind qdr_burst_sram qdr_burst_sram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .k_edge    (k_edge),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .rdata_oe  (rdata_oe),
  .stg_v     (stg_v),
  .write_done(write_done)
);

// File: tb/qdr_burst_sram_bench.sv
module qdr_burst_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int WW    = 18;
  localparam int LW    = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          k_edge;
  logic          rd_n;
  logic [AW-1:0] rd_addr;
  logic          wr_n;
  logic [AW-1:0] wr_addr;
  logic [WW-1:0] wdata;
  logic [1:0]    be_n;
  logic [WW-1:0] rdata;
  logic          rdata_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdr_burst_sram #(.ADDR_W(AW), .WORD_W(WW), .LANE_W(LW)) u_qdr_burst_sram (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .rd_n(rd_n), .rd_addr(rd_addr),
    .wr_n(wr_n), .wr_addr(wr_addr), .wdata(wdata), .be_n(be_n),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  logic [2*WW-1:0] ref_mem [DEPTH];
  logic            q_oe  [4];
  logic [WW-1:0]   q_d   [4];
  string           q_tag [4];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  function automatic logic [2*WW-1:0] merge_ref(input logic [2*WW-1:0] old_w,
      input logic [2*WW-1:0] new_w, input logic [3:0] en);
    logic [2*WW-1:0] r;
    r = old_w;
    for (int i = 0; i < 4; i++)
      if (en[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [WW-1:0] pat(input int a, input int s);
    return WW'(a * 4099 + s * 977 + 18'h15A5A);
  endfunction

  task automatic check_and_shift(input string tag);
    checks++;
    if (rdata_oe !== q_oe[0] || rdata !== q_d[0]) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
               q_tag[0], rdata_oe, rdata, q_oe[0], q_d[0]);
    end
    for (int i = 0; i < 3; i++) begin
      q_oe[i] = q_oe[i+1]; q_d[i] = q_d[i+1]; q_tag[i] = q_tag[i+1];
    end
    q_oe[3] = 1'b0; q_d[3] = '0; q_tag[3] = tag;
  endtask

  // one K period: K edge then K# edge; enables are active high here
  task automatic kcyc(input logic rd, input int ra, input logic wr, input int wa,
      input logic [WW-1:0] lo, input logic [WW-1:0] hi, input logic [3:0] en,
      input string tag, input logic kb_rd = 1'b0, input logic kb_wr = 1'b0);
    @(negedge clk);
    check_and_shift(tag);
    if (wr) ref_mem[wa] = merge_ref(ref_mem[wa], {hi, lo}, en);
    if (rd) begin
      q_oe[2] = 1'b1; q_d[2] = ref_mem[ra][WW-1:0];    q_tag[2] = tag;
      q_oe[3] = 1'b1; q_d[3] = ref_mem[ra][2*WW-1:WW]; q_tag[3] = tag;
    end
    k_edge = 1'b1; rd_n = !rd; rd_addr = AW'(ra); wr_n = !wr;
    wdata = lo; be_n = ~en[1:0]; wr_addr = '0;
    @(negedge clk);
    check_and_shift(tag);
    k_edge = 1'b0; rd_n = !kb_rd; wr_n = !kb_wr; wr_addr = AW'(wa);
    wdata = hi; be_n = ~en[3:2];
  endtask

  task automatic idle(input string tag);
    kcyc(1'b0, 0, 1'b0, 0, '0, '0, 4'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    for (int i = 0; i < 4; i++) begin q_oe[i] = 1'b0; q_d[i] = '0; q_tag[i] = "R3"; end
    rst_n = 1'b0; k_edge = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    rd_addr = '0; wr_addr = '0; wdata = '0; be_n = 2'b11;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R3: reset state and idle bus
    repeat (2) idle("R3");

    // R4, R9: back-to-back full writes over every address
    for (int a = 0; a < DEPTH; a++)
      kcyc(1'b0, 0, 1'b1, a, pat(a, 1), pat(a, 2), 4'hF, "R4 R9");
    // R2, R6, R9: back-to-back reads of every address
    for (int a = 0; a < DEPTH; a++)
      kcyc(1'b1, a, 1'b0, 0, '0, '0, 4'h0, "R2 R6 R9");
    repeat (2) idle("R3");

    // R7: read and write of one address on the same K edge
    for (int a = 0; a < DEPTH; a++)
      kcyc(1'b1, a, 1'b1, a, pat(a, 3), pat(a, 4), 4'hF, "R7");
    // R7: read on the K edge right after the write, neighbour written alongside
    for (int a = 0; a < DEPTH; a++) begin
      kcyc(1'b0, 0, 1'b1, a, pat(a, 5), pat(a, 6), 4'hF, "R7");
      kcyc(1'b1, a, 1'b1, (a + 1) % DEPTH, pat(a, 7), pat(a, 8), 4'hF, "R7");
    end

    // R5, R8: every byte-enable pattern on every address, read on the same edge
    for (int a = 0; a < DEPTH; a++)
      for (int m = 0; m < 16; m++)
        kcyc(1'b1, a, 1'b1, a, pat(a, m + 10), pat(a, m + 40), 4'(m), "R5 R8");
    // R5: contents after commits
    for (int a = 0; a < DEPTH; a++)
      kcyc(1'b1, a, 1'b0, 0, '0, '0, 4'h0, "R5");
    repeat (2) idle("R3");

    // R1: read select low only on the K# edge starts nothing
    kcyc(1'b0, 3, 1'b0, 0, '0, '0, 4'h0, "R1", 1'b1, 1'b0);
    repeat (2) idle("R1");
    // R10: write select low only on the K# edge stores nothing
    kcyc(1'b0, 0, 1'b0, 5, 18'h3FFFF, 18'h3FFFF, 4'h0, "R10", 1'b0, 1'b1);
    kcyc(1'b1, 5, 1'b0, 0, '0, '0, 4'h0, "R10");
    repeat (3) idle("R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule